// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog counter for a small 8-bit microcontroller. It comes out of reset switched off. It does not count until software writes a fixed two-byte key to a dedicated restart register. The key is 0x1E followed directly by 0xE1. Once armed, the counter advances on each machine-cycle tick strobe. Firmware must write the same key again, before the count runs past its range, to bring the count back to zero.

If firmware fails to restart it in time, the block raises a single-cycle reset request for the rest of the system and returns to the disarmed state. No register write can switch it off once it is armed. Only the expiry or a reset clears the armed state.

The count range is a parameter, `CNT_W`, which defaults to 14 bits. Both key bytes are also parameters. The reset input is asynchronous and active low. Its release is synchronised inside the block through a two-stage chain.

Top module: `keyseq_watchdog`

## Requirements
- R1: After reset the block is disarmed, `armed_o` and `rst_req_o` are low, and ticks have no effect while it is disarmed. No request ever appears without arming.
- R2: A write of 0x1E followed by a write of 0xE1 to the restart register (write strobe high with select high) arms a disarmed block. `armed_o` goes high in the cycle after the second write, with the count at zero.
- R3: The same key pair, written while the block is armed, clears the count to zero. The next expiry then needs a full 2^CNT_W ticks counted from that write.
- R4: The key is compared only against the byte of the immediately preceding restart-register write. Any other restart write in between breaks the key. Writes with the select low are ignored and do not replace the remembered byte.
- R5: While the block is armed, the count advances by exactly one in each cycle that has the tick strobe high. Cycles without a tick leave the count unchanged.
- R6: When the count would pass 2^CNT_W−1, the block raises the reset request and disarms. This happens on the 2^CNT_W-th tick after arming or after the last restart.
- R7: The reset request is a registered pulse exactly one cycle wide. It is visible in the cycle that follows the clock edge that sampled the final tick.
- R8: Restart-register writes other than the completed key change neither the count nor the armed state. No write disarms the block.
- R9: Reset clears the remembered previous byte to zero. A 0x1E written before a reset, followed by a 0xE1 written after it, does not arm the block.
- R10: If the key completes in the same cycle as the tick that would expire the count, the restart wins. No request is raised, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| tick_i | input | 1 | Machine-cycle tick strobe, one count per cycle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | High when the write targets the restart register |
| wr_data_i | input | 8 | Write data byte |
| rst_req_o | output | 1 | One-cycle system reset request on expiry |
| armed_o | output | 1 | High while the watchdog is armed and counting |

## Verification
The expiry point is checked with a count range reduced to 5 bits. The sweep restarts the block after every possible number of elapsed ticks, from 1 to 31. Each time it confirms that the next request arrives exactly 32 ticks after the restart, which separates a true clear from a count that merely keeps going. Ticks spaced with irregular idle gaps show that only tick cycles advance the count.

All 256 byte values are written to the restart register while the block is armed. The expiry must still land on the unchanged tick. Broken keys are tried in several forms: an interposed restart write, a lead byte sent with the select low, and a lead byte followed by a reset. These show that the key is tied to the last restart write alone. A key that completes on the expiring tick exercises the priority of restart over expiry.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned WDK_BYTE_W = 8;
  typedef logic [WDK_BYTE_W-1:0] wdk_byte_t;
  localparam wdk_byte_t WDK_KEY_LEAD  = 8'h1E;
  localparam wdk_byte_t WDK_KEY_TRAIL = 8'hE1;
endpackage

// File: rtl/wdk_rst_sync.sv
module wdk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdk_key_match.sv
module wdk_key_match
  import wdk_pkg::*;
#(
  parameter wdk_byte_t KEY_LEAD  = WDK_KEY_LEAD,
  parameter wdk_byte_t KEY_TRAIL = WDK_KEY_TRAIL
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en_i,
  input  logic      wr_sel_i,
  input  wdk_byte_t wr_data_i,
  output logic      kick_o
);
  wdk_byte_t last_q;
  wdk_byte_t last_d;
  logic      load_en;

  assign load_en = wr_en_i & wr_sel_i;

  always_comb begin
    last_d = last_q;
    kick_o = 1'b0;
    if (load_en) begin
      last_d = wr_data_i;
      kick_o = (last_q == KEY_LEAD) && (wr_data_i == KEY_TRAIL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (load_en) last_q <= last_d;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             upd_en;

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    expire_o = 1'b0;
    if (kick_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && tick_i) begin
      if (cnt_q == CNT_MAX) begin
        expire_o = 1'b1;
        armed_d  = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = kick_i | (armed_q & tick_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/wdk_req_reg.sv
module wdk_req_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  output logic req_o
);
  logic req_q, req_d;

  always_comb begin
    req_d = expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/keyseq_watchdog.sv
module keyseq_watchdog
  import wdk_pkg::*;
#(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned SYNC_STG  = 2,
  parameter wdk_byte_t   KEY_LEAD  = WDK_KEY_LEAD,
  parameter wdk_byte_t   KEY_TRAIL = WDK_KEY_TRAIL
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic       rst_req_o,
  output logic       armed_o
);
  logic             rst_core_n;
  logic             kick;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  wdk_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  wdk_key_match #(.KEY_LEAD(KEY_LEAD), .KEY_TRAIL(KEY_TRAIL)) u_key (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .kick_o    (kick)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_i   (tick_i),
    .kick_i   (kick),
    .cnt_o    (cnt),
    .armed_o  (armed_o),
    .expire_o (expire)
  );

  wdk_req_reg u_req (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .expire_i (expire),
    .req_o    (rst_req_o)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int unsigned CNT_W     = 14,
  parameter logic [7:0]  KEY_LEAD  = 8'h1E,
  parameter logic [7:0]  KEY_TRAIL = 8'hE1
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic             rst_req_o,
  input logic             armed_o,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [7:0] shadow_q;
  logic       key_hit;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                shadow_q <= 8'h00;
    else if (wr_en_i && wr_sel_i)   shadow_q <= wr_data_i;
  end

  assign key_hit = wr_en_i && wr_sel_i && (shadow_q == KEY_LEAD) && (wr_data_i == KEY_TRAIL);

  a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!armed_o && !key_hit) |=> (!armed_o && cnt == '0));

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_core_n)
    key_hit |=> (armed_o && cnt == '0 && !rst_req_o));

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_o && tick_i && !key_hit && cnt != CNT_TOP) |=> (armed_o && cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r6_expire_disarms: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_o && tick_i && !key_hit && cnt == CNT_TOP) |=> (rst_req_o && !armed_o));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_req_o |=> !rst_req_o);

  a_r8_no_sw_disable: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_o && !tick_i && !key_hit) |=> (armed_o && $stable(cnt)));

  a_r8_fall_only_on_req: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(armed_o) |-> rst_req_o);
endmodule

bind keyseq_watchdog wdk_checker #(
  .CNT_W     (CNT_W),
  .KEY_LEAD  (KEY_LEAD),
  .KEY_TRAIL (KEY_TRAIL)
) u_wdk_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .rst_req_o  (rst_req_o),
  .armed_o    (armed_o),
  .cnt        (cnt)
);

// File: tb/tb_keyseq_watchdog.sv
module tb_keyseq_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 5;
  localparam int LIMIT      = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, wr_en_i, wr_sel_i;
  logic [7:0] wr_data_i;
  logic       rst_req_o, armed_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyseq_watchdog #(.CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rst_req_o (rst_req_o),
    .armed_o   (armed_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit we, input bit sel, input logic [7:0] d);
    tick_i = t; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic wr(input logic [7:0] d, input bit sel);
    step(1'b0, 1'b1, sel, d);
  endtask

  task automatic arm();
    wr(8'h1E, 1'b1);
    wr(8'hE1, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic ticks(input int n, output int first, output int hits);
    first = 0; hits = 0;
    for (int i = 1; i <= n; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00);
      if (rst_req_o) begin
        hits++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int first, hits;
    tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = 8'h00;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state and ticks while disarmed
    check("R1 armed after reset", int'(armed_o), 0);
    check("R1 req after reset", int'(rst_req_o), 0);
    ticks(3 * LIMIT, first, hits);
    check("R1 no request while disarmed", hits, 0);
    check("R1 still disarmed", int'(armed_o), 0);

    // R4: broken keys
    wr(8'h1E, 1'b1); wr(8'h55, 1'b1); wr(8'hE1, 1'b1);
    check("R4 interposed write breaks key", int'(armed_o), 0);
    wr(8'hE1, 1'b1);
    check("R4 lone trail byte", int'(armed_o), 0);
    wr(8'h1E, 1'b0); wr(8'hE1, 1'b1);
    check("R4 lead with select low", int'(armed_o), 0);
    wr(8'h1E, 1'b1); wr(8'h77, 1'b0); wr(8'hE1, 1'b1);
    check("R4 unselected write leaves remembered byte", int'(armed_o), 1);
    ticks(LIMIT, first, hits);
    check("R6 expiry after arming via kept byte", first, LIMIT);

    // R9: remembered byte cleared by reset
    wr(8'h1E, 1'b1);
    do_reset();
    wr(8'hE1, 1'b1);
    check("R9 lead before reset does not count", int'(armed_o), 0);

    // R2, R6, R7: plain arm and expiry
    arm();
    check("R2 armed after key", int'(armed_o), 1);
    check("R2 no request on arm", int'(rst_req_o), 0);
    ticks(LIMIT, first, hits);
    check("R6 expiry tick index", first, LIMIT);
    check("R7 request seen once", hits, 1);
    check("R6 disarmed after expiry", int'(armed_o), 0);
    idle(1);
    check("R7 request one cycle wide", int'(rst_req_o), 0);
    ticks(2 * LIMIT, first, hits);
    check("R1 no request after expiry", hits, 0);

    // R3: restart after every possible elapsed count
    for (int k = 1; k < LIMIT; k++) begin
      arm();
      ticks(k, first, hits);
      check("R3 no early request", hits, 0);
      arm();
      check("R3 still armed after restart", int'(armed_o), 1);
      ticks(LIMIT, first, hits);
      check("R3 full window after restart", first, LIMIT);
      check("R7 single pulse after restart", hits, 1);
    end

    // R5: ticks with idle gaps
    arm();
    first = 0;
    for (int i = 1; i <= LIMIT; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00);
      if (rst_req_o && first == 0) first = i;
      idle(i % 3);
      if (rst_req_o && first == 0) first = -i;
    end
    check("R5 only tick cycles count", first, LIMIT);

    // R8: every byte value written while armed
    arm();
    ticks(10, first, hits);
    for (int v = 0; v < 256; v++) wr(8'(v), 1'b1);
    check("R8 armed after byte sweep", int'(armed_o), 1);
    ticks(LIMIT - 10, first, hits);
    check("R8 count untouched by other writes", first, LIMIT - 10);

    // R10: key completes on the expiring tick
    arm();
    ticks(LIMIT - 1, first, hits);
    check("R10 no request before final tick", hits, 0);
    wr(8'h1E, 1'b1);
    step(1'b1, 1'b1, 1'b1, 8'hE1);
    check("R10 restart wins over expiry", int'(rst_req_o), 0);
    check("R10 still armed", int'(armed_o), 1);
    ticks(LIMIT, first, hits);
    check("R10 full window after coincident restart", first, LIMIT);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule